// File: doc/BRIEF.md
# Clamp/Sample Strobe Generator

This block produces the clamp and sample strobes that pace the input stage of a pixel-rate analog front end. Each pixel period is split into 64 phase positions by a free-running 6-bit phase counter, which stands in for the delay-locked loop of a real front end. Four 6-bit edge indices place the rising and falling phase of the clamp strobe and of the sample strobe. Configuration changes are taken up only at the pixel boundary, so a strobe is never cut short in the middle of a pixel.

A parity flag alternates between even and odd pixels. Each strobe is issued on an even copy during even pixels and on an odd copy during odd pixels. The clamp strobe is produced only in correlated-double-sample mode. The block also gives an optional version of the external clamp input that is ANDed with the generated clamp, an ADC clock that is high for the first half of the pixel, and two debug pins whose source is chosen by a 2-bit select.

Top module: `pix_strobe_gen`

## Requirements
- R1: The phase output is 0 while reset is held and for the cycle after reset is released. It then advances by one each clock and wraps from 63 to 0.
- R2: A strobe is high while rise index <= phase < fall index. When the rise index is equal to or greater than the fall index, the strobe never asserts.
- R3: The clamp strobes are forced low when `cds_en` is 0, and this takes effect at once. The sample strobes do not depend on `cds_en`.
- R4: The first pixel after reset is even. Parity flips at each wrap from 63 to 0. Even outputs can be high only in even pixels, and odd outputs only in odd pixels.
- R5: The four index inputs are sampled on the clock edge that leaves phase 63, and they govern the whole of the next pixel. A change made in the middle of a pixel has no effect until then. The first pixel after reset uses clamp 8..28 and sample 40..60.
- R6: Only bits [5:0] of each 8-bit index input are used. Bits [7:6] have no effect.
- R7: With `gate_en` = 1, `clp_out` = `clpin` AND (the active clamp strobe). With `gate_en` = 0, `clp_out` = `clpin`.
- R8: The monitor select works as follows. 00 drives both pins low. 01 gives mon0 = even clamp and mon1 = even sample. 10 gives mon0 = odd clamp and mon1 = odd sample. 11 gives mon0 = odd-pixel flag and mon1 = ADC clock.
- R9: `adc_clk` is high for phases 0 to 31 and low for phases 32 to 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cds_en | input | 1 | Correlated-double-sample mode, enables clamp |
| gate_en | input | 1 | Gate clamp input with generated clamp |
| mon_sel | input | 2 | Debug monitor source select |
| clamp_rise_cfg | input | 8 | Clamp rising phase, bits [5:0] used |
| clamp_fall_cfg | input | 8 | Clamp falling phase, bits [5:0] used |
| samp_rise_cfg | input | 8 | Sample rising phase, bits [5:0] used |
| samp_fall_cfg | input | 8 | Sample falling phase, bits [5:0] used |
| clpin | input | 1 | External clamp input |
| phase_o | output | 6 | Current phase position |
| clamp_even | output | 1 | Clamp strobe, even pixels |
| clamp_odd | output | 1 | Clamp strobe, odd pixels |
| samp_even | output | 1 | Sample strobe, even pixels |
| samp_odd | output | 1 | Sample strobe, odd pixels |
| adc_clk | output | 1 | ADC clock, high for phases 0 to 31 |
| clp_out | output | 1 | Clamp input, optionally gated |
| mon0 | output | 1 | Debug monitor pin 0 |
| mon1 | output | 1 | Debug monitor pin 1 |

## Verification
The hardest case to reach is a configuration change that lands in the middle of a pixel. It has to leave the running pixel alone and then appear in full from the next phase 0. The bench tracks the phase by counting cycles, so it knows which pixel it is in. It rewrites the indices at phase 10 of a pixel and checks every remaining phase against the old windows, then checks the next pixel against the new ones. A reset asserted partway through a pixel is also driven, to show that the reset defaults and even parity come back.

// File: rtl/pix_strobe_pkg.sv
// Shared types and counts for the clamp/sample strobe generator.
package pix_strobe_pkg;
    // Debug monitor source encoding
    typedef enum logic [1:0] {
        MON_OFF  = 2'b00,
        MON_EVEN = 2'b01,
        MON_ODD  = 2'b10,
        MON_TAG  = 2'b11
    } mon_sel_e;

    localparam int unsigned STROBE_N = 2;            // clamp, sample
    localparam int unsigned EDGE_N   = 2 * STROBE_N; // rise/fall per strobe
endpackage

// File: rtl/pix_phase_ctr.sv
// Free-running phase counter with a pixel parity flag.
// Assumes one clock per phase position; wraps after 2**PW phases.
module pix_phase_ctr #(
    parameter int unsigned PW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [PW-1:0] phase,
    output logic          odd,
    output logic          last
);
    localparam logic [PW-1:0] LAST_PH = {PW{1'b1}};

    assign last = (phase == LAST_PH);

    // Advance phase once per clock, wrapping naturally
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= '0;
        else        phase <= phase + PW'(1);
    end

    // Flip pixel parity on leaving the last phase
    always_ff @(posedge clk) begin
        if (!rst_n)    odd <= 1'b0;
        else if (last) odd <= ~odd;
    end
endmodule

// File: rtl/pix_idx_shadow.sv
// Shadow registers for the edge indices; loaded only when 'load' is high.
// Assumes 'load' marks the pixel boundary so a running pixel never sees a change.
module pix_idx_shadow #(
    parameter int unsigned        PW   = 6,
    parameter int unsigned        N    = 4,
    parameter logic [N*PW-1:0]    INIT = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [N*PW-1:0] d,
    output logic [N*PW-1:0] q
);
    for (genvar g = 0; g < N; g++) begin : g_idx
        logic [PW-1:0] r;
        // Hold one index, reload at the boundary
        always_ff @(posedge clk) begin
            if (!rst_n)    r <= INIT[g*PW +: PW];
            else if (load) r <= d[g*PW +: PW];
        end
        assign q[g*PW +: PW] = r;
    end
endmodule

// File: rtl/pix_window.sv
// Phase window comparator: active for rise <= phase < fall.
// An empty or inverted window (rise >= fall) never asserts.
module pix_window #(
    parameter int unsigned PW = 6
) (
    input  logic [PW-1:0] phase,
    input  logic [PW-1:0] rise,
    input  logic [PW-1:0] fall,
    output logic          active
);
    assign active = (phase >= rise) && (phase < fall);
endmodule

// File: rtl/pix_mon_mux.sv
// Two-pin debug monitor multiplexer; select 00 drives both pins low.
module pix_mon_mux
    import pix_strobe_pkg::*;
(
    input  logic [1:0] sel,
    input  logic       clamp_even,
    input  logic       samp_even,
    input  logic       clamp_odd,
    input  logic       samp_odd,
    input  logic       odd_tag,
    input  logic       adc_clk,
    output logic       mon0,
    output logic       mon1
);
    // Route the selected pair to the debug pins
    always_comb begin
        case (mon_sel_e'(sel))
            MON_EVEN: begin mon0 = clamp_even; mon1 = samp_even; end
            MON_ODD:  begin mon0 = clamp_odd;  mon1 = samp_odd;  end
            MON_TAG:  begin mon0 = odd_tag;    mon1 = adc_clk;   end
            default:  begin mon0 = 1'b0;       mon1 = 1'b0;      end
        endcase
    end
endmodule

// File: rtl/pix_strobe_gen.sv
// Top: programmable clamp/sample strobe generator.
// Indices are shadowed at the last phase of each pixel; clamp is gated by
// correlated-double-sample mode; strobes are split by pixel parity.
module pix_strobe_gen
    import pix_strobe_pkg::*;
#(
    parameter int unsigned PHASE_W        = 6,
    parameter int unsigned CFG_W          = 8,
    parameter int unsigned CLAMP_RISE_RST = 8,
    parameter int unsigned CLAMP_FALL_RST = 28,
    parameter int unsigned SAMP_RISE_RST  = 40,
    parameter int unsigned SAMP_FALL_RST  = 60
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cds_en,
    input  logic               gate_en,
    input  logic [1:0]         mon_sel,
    input  logic [CFG_W-1:0]   clamp_rise_cfg,
    input  logic [CFG_W-1:0]   clamp_fall_cfg,
    input  logic [CFG_W-1:0]   samp_rise_cfg,
    input  logic [CFG_W-1:0]   samp_fall_cfg,
    input  logic               clpin,
    output logic [PHASE_W-1:0] phase_o,
    output logic               clamp_even,
    output logic               clamp_odd,
    output logic               samp_even,
    output logic               samp_odd,
    output logic               adc_clk,
    output logic               clp_out,
    output logic               mon0,
    output logic               mon1
);
    localparam int unsigned PW = PHASE_W;
    localparam logic [EDGE_N*PW-1:0] IDX_INIT = {
        PW'(SAMP_FALL_RST), PW'(SAMP_RISE_RST),
        PW'(CLAMP_FALL_RST), PW'(CLAMP_RISE_RST)
    };

    logic [PW-1:0]        phase;
    logic                 pix_odd;
    logic                 pix_last;
    logic [EDGE_N*PW-1:0] cfg_idx;
    logic [EDGE_N*PW-1:0] sh_idx;
    logic [STROBE_N-1:0]  win;
    logic                 clamp_act;
    logic                 samp_act;
    logic                 unused_cfg_hi;

    // Only the low PW bits of each index input carry meaning
    assign cfg_idx = {samp_fall_cfg[PW-1:0], samp_rise_cfg[PW-1:0],
                      clamp_fall_cfg[PW-1:0], clamp_rise_cfg[PW-1:0]};
    assign unused_cfg_hi = ^{samp_fall_cfg[CFG_W-1:PW], samp_rise_cfg[CFG_W-1:PW],
                             clamp_fall_cfg[CFG_W-1:PW], clamp_rise_cfg[CFG_W-1:PW]};

    pix_phase_ctr #(.PW(PW)) ctr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (phase),
        .odd   (pix_odd),
        .last  (pix_last)
    );

    pix_idx_shadow #(.PW(PW), .N(EDGE_N), .INIT(IDX_INIT)) shadow_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (pix_last),
        .d     (cfg_idx),
        .q     (sh_idx)
    );

    // One window comparator per strobe (0 = clamp, 1 = sample)
    for (genvar s = 0; s < STROBE_N; s++) begin : g_win
        pix_window #(.PW(PW)) win_i (
            .phase  (phase),
            .rise   (sh_idx[(2*s)*PW +: PW]),
            .fall   (sh_idx[(2*s+1)*PW +: PW]),
            .active (win[s])
        );
    end

    assign clamp_act  = win[0] & cds_en;
    assign samp_act   = win[1];

    assign clamp_even = clamp_act & ~pix_odd;
    assign clamp_odd  = clamp_act &  pix_odd;
    assign samp_even  = samp_act  & ~pix_odd;
    assign samp_odd   = samp_act  &  pix_odd;

    assign adc_clk    = ~phase[PW-1];
    assign clp_out    = gate_en ? (clpin & clamp_act) : clpin;
    assign phase_o    = phase;

    pix_mon_mux mon_i (
        .sel        (mon_sel),
        .clamp_even (clamp_even),
        .samp_even  (samp_even),
        .clamp_odd  (clamp_odd),
        .samp_odd   (samp_odd),
        .odd_tag    (pix_odd),
        .adc_clk    (adc_clk),
        .mon0       (mon0),
        .mon1       (mon1)
    );
endmodule

// File: rtl/pix_strobe_chk.sv
// Property checker for pix_strobe_gen, attached with bind below.
module pix_strobe_chk #(
    parameter int unsigned PW = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cds_en,
    input logic            gate_en,
    input logic            clpin,
    input logic [1:0]      mon_sel,
    input logic [PW-1:0]   phase_o,
    input logic            clamp_even,
    input logic            clamp_odd,
    input logic            samp_even,
    input logic            samp_odd,
    input logic            adc_clk,
    input logic            clp_out,
    input logic            mon0,
    input logic            mon1,
    input logic [4*PW-1:0] sh_idx,
    input logic            pix_odd
);
    localparam logic [PW-1:0] LAST_PH = {PW{1'b1}};
    localparam logic [PW-1:0] HALF_PH = {1'b1, {(PW-1){1'b0}}};

    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (phase_o == PW'($past(phase_o) + PW'(1)))); // R1
    AST_EMPTY_SAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_idx[2*PW +: PW] >= sh_idx[3*PW +: PW]) |-> !(samp_even || samp_odd)); // R2
    AST_CLAMP_SH: assert property (@(posedge clk) disable iff (!rst_n)
        !cds_en |-> !(clamp_even || clamp_odd)); // R3
    AST_PARITY_ODD: assert property (@(posedge clk) disable iff (!rst_n)
        pix_odd |-> !(clamp_even || samp_even)); // R4
    AST_PARITY_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_odd |-> !(clamp_odd || samp_odd)); // R4
    AST_PARITY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o != LAST_PH) |=> $stable(pix_odd)); // R4
    AST_PARITY_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == LAST_PH) |=> (pix_odd != $past(pix_odd))); // R4
    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o != LAST_PH) |=> $stable(sh_idx)); // R5
    AST_GATE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_en |-> (clp_out == clpin)); // R7
    AST_GATE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_en && !(clamp_even || clamp_odd)) |-> !clp_out); // R7
    AST_MON_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_sel == 2'b00) |-> !(mon0 || mon1)); // R8
    AST_ADC_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == '0) |-> adc_clk); // R9
    AST_ADC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == HALF_PH) |-> !adc_clk); // R9
endmodule

bind pix_strobe_gen pix_strobe_chk #(.PW(PHASE_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cds_en     (cds_en),
    .gate_en    (gate_en),
    .clpin      (clpin),
    .mon_sel    (mon_sel),
    .phase_o    (phase_o),
    .clamp_even (clamp_even),
    .clamp_odd  (clamp_odd),
    .samp_even  (samp_even),
    .samp_odd   (samp_odd),
    .adc_clk    (adc_clk),
    .clp_out    (clp_out),
    .mon0       (mon0),
    .mon1       (mon1),
    .sh_idx     (sh_idx),
    .pix_odd    (pix_odd)
);

// File: tb/pix_strobe_gen_tb_top.sv
// Self-checking bench: table of per-pixel vectors, then directed cases.
module pix_strobe_gen_tb_top;
    localparam real CLK_HALF = 2.5; // 200 MHz
    localparam int  WD_NS    = 200000;

    typedef struct packed {
        logic       cds;
        logic       gate;
        logic [1:0] mon;
        logic [7:0] cr;
        logic [7:0] cf;
        logic [7:0] sr;
        logic [7:0] sf;
        logic       clp;
    } vec_t;

    localparam int NV     = 8;
    localparam int IDX_R6 = 7;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 2'b01, 8'd8,    8'd28,   8'd40,   8'd60,   1'b1},
        '{1'b0, 1'b0, 2'b10, 8'd8,    8'd28,   8'd40,   8'd60,   1'b1},
        '{1'b1, 1'b1, 2'b10, 8'd0,    8'd63,   8'd0,    8'd63,   1'b1},
        '{1'b1, 1'b1, 2'b11, 8'd20,   8'd20,   8'd5,    8'd5,    1'b0},
        '{1'b1, 1'b0, 2'b11, 8'd50,   8'd10,   8'd63,   8'd2,    1'b1},
        '{1'b1, 1'b1, 2'b00, 8'd31,   8'd33,   8'd32,   8'd33,   1'b1},
        '{1'b0, 1'b1, 2'b01, 8'd4,    8'd60,   8'd10,   8'd11,   1'b1},
        '{1'b1, 1'b0, 2'b10, 8'hC3,   8'h4A,   8'h85,   8'hFF,   1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cds_en, gate_en, clpin;
    logic [1:0] mon_sel;
    logic [7:0] clamp_rise_cfg, clamp_fall_cfg, samp_rise_cfg, samp_fall_cfg;
    logic [5:0] phase_o;
    logic       clamp_even, clamp_odd, samp_even, samp_odd;
    logic       adc_clk, clp_out, mon0, mon1;

    // Bench model state, built from the requirements
    int         bc;
    logic       odd_m;
    logic [5:0] sh [4];
    logic [7:0] cur [4];
    logic       cds_m, gate_m, clp_base;
    logic [1:0] mon_m;
    int         n_chk = 0;
    int         n_fail = 0;
    bit         done = 0;

    always #(CLK_HALF) clk = ~clk;

    pix_strobe_gen dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .cds_en         (cds_en),
        .gate_en        (gate_en),
        .mon_sel        (mon_sel),
        .clamp_rise_cfg (clamp_rise_cfg),
        .clamp_fall_cfg (clamp_fall_cfg),
        .samp_rise_cfg  (samp_rise_cfg),
        .samp_fall_cfg  (samp_fall_cfg),
        .clpin          (clpin),
        .phase_o        (phase_o),
        .clamp_even     (clamp_even),
        .clamp_odd      (clamp_odd),
        .samp_even      (samp_even),
        .samp_odd       (samp_odd),
        .adc_clk        (adc_clk),
        .clp_out        (clp_out),
        .mon0           (mon0),
        .mon1           (mon1)
    );

    task automatic set_defaults();
        sh[0] = 6'd8; sh[1] = 6'd28; sh[2] = 6'd40; sh[3] = 6'd60; // R5 defaults
    endtask

    task automatic chk(input string ctx, input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h (phase %0d)", ctx, tag, act, exp, bc);
        end
    endtask

    task automatic drive();
        cds_en = cds_m; gate_en = gate_m; mon_sel = mon_m;
        clamp_rise_cfg = cur[0]; clamp_fall_cfg = cur[1];
        samp_rise_cfg  = cur[2]; samp_fall_cfg  = cur[3];
        clpin = clp_base ^ bc[2];
    endtask

    task automatic check(input string ctx);
        logic [5:0] ph;
        logic cw, sw, e_clp, e_m0, e_m1, e_adc;
        ph = bc[5:0];
        cw = (ph >= sh[0]) && (ph < sh[1]) && cds_m;
        sw = (ph >= sh[2]) && (ph < sh[3]);
        e_adc = (ph < 6'd32);
        e_clp = gate_m ? (clpin & cw) : clpin;
        case (mon_m)
            2'b01:   begin e_m0 = cw & ~odd_m; e_m1 = sw & ~odd_m; end
            2'b10:   begin e_m0 = cw &  odd_m; e_m1 = sw &  odd_m; end
            2'b11:   begin e_m0 = odd_m;       e_m1 = e_adc;       end
            default: begin e_m0 = 1'b0;        e_m1 = 1'b0;        end
        endcase
        chk(ctx, "R1 phase", {2'b00, phase_o}, {2'b00, ph});
        chk(ctx, "R3 clamp", {6'd0, clamp_odd, clamp_even}, {6'd0, cw & odd_m, cw & ~odd_m});
        chk(ctx, "R2 R4 samp", {6'd0, samp_odd, samp_even}, {6'd0, sw & odd_m, sw & ~odd_m});
        chk(ctx, "R9 adc", {7'd0, adc_clk}, {7'd0, e_adc});
        chk(ctx, "R7 clp", {7'd0, clp_out}, {7'd0, e_clp});
        chk(ctx, "R8 mon", {6'd0, mon0, mon1}, {6'd0, e_m0, e_m1});
    endtask

    // Advance one clock and update the model the way the requirements state
    task automatic tick();
        @(posedge clk);
        if (!rst_n) begin
            bc = 0; odd_m = 1'b0; set_defaults();
        end else begin
            if (bc == 63) begin
                for (int g = 0; g < 4; g++) sh[g] = cur[g][5:0];
                odd_m = ~odd_m;
            end
            bc = (bc + 1) % 64;
        end
        #1;
    endtask

    task automatic step(input string ctx);
        drive(); #1; check(ctx); tick();
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        #(WD_NS);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; bc = 0; odd_m = 1'b0; set_defaults();
        cur[0] = 8'd30; cur[1] = 8'd40; cur[2] = 8'd1; cur[3] = 8'd2;
        cds_m = 1'b1; gate_m = 1'b0; mon_m = 2'b01; clp_base = 1'b1;
        drive();
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset state");
        rst_n = 1'b1;
        // First pixel runs on reset defaults although inputs differ (R5)
        for (int k = 0; k < 63; k++) step("R5 reset defaults");

        // Table walk: each vector governs one whole pixel
        for (int v = 0; v < NV; v++) begin
            string ctx;
            ctx = (v == IDX_R6) ? "R6 upper bits" : "R2 table";
            cds_m = VECS[v].cds; gate_m = VECS[v].gate; mon_m = VECS[v].mon;
            clp_base = VECS[v].clp;
            cur[0] = VECS[v].cr; cur[1] = VECS[v].cf;
            cur[2] = VECS[v].sr; cur[3] = VECS[v].sf;
            for (int k = 0; k < 64; k++) step(ctx);
        end

        // Mid-pixel index change must wait for the boundary (R5)
        cds_m = 1'b1; gate_m = 1'b1; mon_m = 2'b01; clp_base = 1'b1;
        cur[0] = 8'd0; cur[1] = 8'd63; cur[2] = 8'd0; cur[3] = 8'd63;
        for (int k = 0; k < 11; k++) step("R5 setup");
        cur[0] = 8'd30; cur[1] = 8'd31; cur[2] = 8'd62; cur[3] = 8'd63;
        for (int k = 0; k < 53; k++) step("R5 mid-pixel hold");
        for (int k = 0; k < 64; k++) step("R5 next pixel");

        // Live mode change takes effect at once (R3)
        for (int k = 0; k < 30; k++) step("R3 cds on");
        cds_m = 1'b0;
        for (int k = 0; k < 4; k++) step("R3 cds off");

        // Reset partway through a pixel (R1, R4)
        cds_m = 1'b1; mon_m = 2'b11;
        rst_n = 1'b0;
        step("R1 reset in run");
        drive(); #1; check("R1 reset held");
        rst_n = 1'b1;
        for (int k = 0; k < 70; k++) step("R4 parity after reset");

        done = 1;
        summary();
        $finish;
    end
endmodule